// File: doc/BRIEF.md
# Pixel-Clock Load, Divided-Clock and Shift-Gate Generator

This block runs entirely on the pixel clock and derives three control outputs for a frame-buffer interface. The first is a load strobe. It is a one-cycle enable pulse whose rate is either every pixel clock or every second pixel clock, depending on a pixel-pairing mode bit. The second is a programmable divided clock. It is a 50% duty square wave at the pixel clock divided by 4, 8, 16 or 32, and it is phase-locked so that every rising edge lands in a cycle where the load strobe is high. The third is a shift-clock output. It is the incoming shift-clock signal ANDed with the active-low blank after the blank has been registered into the pixel clock domain, so shifting stops during retrace.

A single phase counter drives both the strobe and the divided clock. The configuration inputs are registered. Any change in them restarts the counter, so the new rates begin cleanly from phase zero. The strobe is an enable rather than a second clock, so no extra clock domain is created. The block moves no data stream; all pins are plain control signals without a handshake.

Top module: `vid_strobe_gen`

## Requirements
- R1: With `pair_mode`=1 the load strobe is high in phase 0 and every even phase, and low in odd phases (half the pixel rate).
- R2: With `pair_mode`=0 the load strobe is high in every cycle (full pixel rate).
- R3: `prog_clk` has period N = 4, 8, 16, 32 pixel clocks for `div_sel` = 00, 01, 10, 11 and is high for phases 0..N/2-1 of each period (50% duty).
- R4: Every rising edge of `prog_clk` falls in a cycle where `load_strobe` is high.
- R5: Reset is synchronous and active high. In the first cycle after reset is released, the phase is 0, so `load_strobe` and `prog_clk` are both high. While in reset `shift_out` is low.
- R6: When `pair_mode` or `div_sel` differs from the value in use at a clock edge, the new setting takes effect from that edge and the phase restarts at 0. The first cycle after that edge therefore shows both outputs high, with the new rates.
- R7: When `blank_n` was high at the previous clock edge (not in reset), `shift_out` equals `shift_in`.
- R8: When `blank_n` was low at the previous clock edge, `shift_out` is low whatever `shift_in` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pair_mode | input | 1 | 1 = load strobe at half pixel rate, 0 = full rate |
| div_sel | input | 2 | Divided-clock select: 00=/4, 01=/8, 10=/16, 11=/32 |
| shift_in | input | 1 | Incoming shift-clock signal |
| blank_n | input | 1 | Blank, active low (low = retrace) |
| load_strobe | output | 1 | Load enable pulse |
| prog_clk | output | 1 | Divided clock, rising edges aligned to load strobe |
| shift_out | output | 1 | Shift clock gated by synchronized blank |

## Verification
The bench sweeps all eight mode/divider combinations from reset. It checks every cycle over two full /32 periods against a phase count kept by the bench. A wrong tap choice would show a period off by a factor of two, and an inverted decode would start low after reset. Mid-period configuration changes at varied phases test that the restart lands on phase 0; a design that fails to restart would keep the old phase, and the first checked cycle would show `prog_clk` low or the strobe missing. The shift gate is driven through all combinations of shift input and blank with a one-cycle blank delay. A design that used blank unregistered, or the wrong polarity, would let a shift pulse through during retrace or cut one off after it.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int DIV_SEL_W = 2;
  localparam int NUM_DIV   = 2 ** DIV_SEL_W;
  // smallest divide is 4 -> tap bit 1; largest tap is bit NUM_DIV
  localparam int PHASE_W   = NUM_DIV + 1;

  typedef struct packed {
    logic                 pair_mode;
    logic [DIV_SEL_W-1:0] div_sel;
  } vsg_cfg_t;
endpackage

// File: rtl/vsg_cfg_track.sv
module vsg_cfg_track
  import vsg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  vsg_cfg_t cfg_in,
  output vsg_cfg_t cfg_q,
  output logic     restart
);
  // a differing request restarts the phase on the same edge it is adopted
  assign restart = (cfg_in != cfg_q);

  always_ff @(posedge clk) begin
    cfg_q <= cfg_in;
  end
endmodule

// File: rtl/vsg_phase_ctr.sv
module vsg_phase_ctr #(
  parameter int W = vsg_pkg::PHASE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst || restart) phase <= '0;
    else                phase <= phase + 1'b1;
  end
endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
  import vsg_pkg::*;
(
  input  logic [PHASE_W-1:0] phase,
  input  vsg_cfg_t           cfg,
  output logic               load_strobe,
  output logic               prog_clk
);
  logic [NUM_DIV-1:0] taps;

  // tap g gives period 2^(g+2), high in the first half
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_tap
    assign taps[g] = ~phase[g+1];
  end

  assign prog_clk    = taps[cfg.div_sel];
  assign load_strobe = cfg.pair_mode ? ~phase[0] : 1'b1;
endmodule

// File: rtl/vsg_shift_gate.sv
module vsg_shift_gate #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_in,
  input  logic blank_n,
  output logic shift_out
);
  logic [STAGES-1:0] sync_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= blank_n;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[STAGES-2:0], blank_n};
    end
  end

  assign shift_out = shift_in & sync_q[STAGES-1];
endmodule

// File: rtl/vid_strobe_gen.sv
module vid_strobe_gen
  import vsg_pkg::*;
#(
  parameter int BLANK_STAGES = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pair_mode,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic                 shift_in,
  input  logic                 blank_n,
  output logic                 load_strobe,
  output logic                 prog_clk,
  output logic                 shift_out
);
  vsg_cfg_t           cfg_req;
  vsg_cfg_t           cfg_act;
  logic               restart;
  logic [PHASE_W-1:0] phase;

  assign cfg_req.pair_mode = pair_mode;
  assign cfg_req.div_sel   = div_sel;

  vsg_cfg_track u_cfg (
    .clk(clk), .rst(rst), .cfg_in(cfg_req), .cfg_q(cfg_act), .restart(restart)
  );

  vsg_phase_ctr #(.W(PHASE_W)) u_ctr (
    .clk(clk), .rst(rst), .restart(restart), .phase(phase)
  );

  vsg_decode u_dec (
    .phase(phase), .cfg(cfg_act), .load_strobe(load_strobe), .prog_clk(prog_clk)
  );

  vsg_shift_gate #(.STAGES(BLANK_STAGES)) u_gate (
    .clk(clk), .rst(rst), .shift_in(shift_in), .blank_n(blank_n), .shift_out(shift_out)
  );
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker (
  input logic       clk,
  input logic       rst,
  input logic       pair_mode,
  input logic [1:0] div_sel,
  input logic       shift_in,
  input logic       blank_n,
  input logic       load_strobe,
  input logic       prog_clk,
  input logic       shift_out
);
  p_strobe_alt_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(pair_mode) && pair_mode && $stable(div_sel)) |=> (load_strobe != $past(load_strobe)));

  p_strobe_full_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(pair_mode) |-> load_strobe);

  p_rise_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_clk) |-> load_strobe);

  p_reset_phase_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (load_strobe && prog_clk));

  p_restart_phase_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(pair_mode) != $past(pair_mode, 2) || $past(div_sel) != $past(div_sel, 2))
      |-> (load_strobe && prog_clk));

  p_shift_pass_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(blank_n) && !$past(rst)) |-> (shift_out == shift_in));

  p_blank_stop_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(blank_n) |-> !shift_out);
endmodule

bind vid_strobe_gen vsg_checker u_vsg_chk (
  .clk(clk), .rst(rst), .pair_mode(pair_mode), .div_sel(div_sel),
  .shift_in(shift_in), .blank_n(blank_n), .load_strobe(load_strobe),
  .prog_clk(prog_clk), .shift_out(shift_out)
);

// File: tb/tb_vid_strobe_gen.sv
`timescale 1ns/1ps
module tb_vid_strobe_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pair_mode = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic       shift_in = 1'b0;
  logic       blank_n = 1'b0;
  logic       load_strobe, prog_clk, shift_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  vid_strobe_gen dut (
    .clk(clk), .rst(rst), .pair_mode(pair_mode), .div_sel(div_sel),
    .shift_in(shift_in), .blank_n(blank_n), .load_strobe(load_strobe),
    .prog_clk(prog_clk), .shift_out(shift_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge where the design sits at phase 0 of (m,d).
  task automatic phase_run(input logic m, input logic [1:0] d, input int len, input string tag0);
    int  n;
    logic prev;
    n    = 4 << d;
    prev = 1'b1;
    for (int i = 0; i < len; i++) begin
      if (i == 0) begin
        chk(tag0, load_strobe, 1'b1);
        chk(tag0, prog_clk, 1'b1);
      end
      if (m) chk("R1", load_strobe, (i % 2) == 0);
      else   chk("R2", load_strobe, 1'b1);
      chk("R3", prog_clk, (i % n) < (n / 2));
      if (i > 0 && !prev && prog_clk) chk("R4", load_strobe, 1'b1);
      prev = prog_clk;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic bprev;
    // reset state
    @(negedge clk);
    chk("R5", shift_out, 1'b0);
    chk("R5", load_strobe, 1'b1);
    chk("R5", prog_clk, 1'b1);

    // R5 / R1 / R2 / R3 / R4: every configuration from reset
    for (int c = 0; c < 8; c++) begin
      rst = 1'b1;
      pair_mode = c[2];
      div_sel = c[1:0];
      @(negedge clk);
      rst = 1'b0;
      phase_run(c[2], c[1:0], 70, "R5");
    end

    // R6: restart on configuration change at varied phases
    for (int a = 0; a < 8; a++) begin
      int b;
      b = (a + 3) % 8;
      rst = 1'b1;
      pair_mode = a[2];
      div_sel = a[1:0];
      @(negedge clk);
      rst = 1'b0;
      phase_run(a[2], a[1:0], 5 + 2 * a, "R5");
      pair_mode = b[2];
      div_sel = b[1:0];
      @(negedge clk);
      phase_run(b[2], b[1:0], 40, "R6");
    end

    // R7 / R8: shift gating with one-cycle synchronized blank
    bprev = blank_n;
    for (int s = 0; s < 48; s++) begin
      logic si, bi;
      si = s[0];
      bi = s[1] ^ s[3] ^ s[4];
      shift_in = si;
      blank_n  = bi;
      #1;
      if (bprev) chk("R7", shift_out, si);
      else       chk("R8", shift_out, 1'b0);
      bprev = bi;
      @(negedge clk);
    end

    // R8: shift input toggling inside a long blanking interval
    blank_n = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      shift_in = s[0];
      #1;
      chk("R8", shift_out, 1'b0);
      @(negedge clk);
    end

    summary();
    $finish;
  end
endmodule